// File: doc/BRIEF.md
# Interrupt-Capable GPIO Port

This block is one byte-wide general-purpose I/O port for a chip's peripheral bus. Each line can be driven as an output or sampled as an input. An input line can also raise an interrupt. A small synchronous byte register interface sets the output value, the direction of each line and the interrupt configuration. Every register uses one bit per line, at the same bit position as that line.

An input line that can interrupt first passes through a two-flop synchronizer. An optional per-line filter can follow, which accepts a new level only after it has been steady for several prescaled sample ticks. The filtered level feeds the detector. Each line has two configuration bits, giving four trigger modes:

- The sense bit picks level (0) or edge (1).
- The polarity bit picks low or falling (0), or high or rising (1).

Captured edges stay pending until software writes a 1 to that bit of the acknowledge register. Level interrupts follow the input directly.

Enabled pending bits appear in a read-only status register. They also drive eight per-line interrupt outputs and one combined output, all registered.

Register addresses:

| Register | Address | Access | Meaning of a bit set to 1 |
|---|---|---|---|
| data | 0x00 | read/write | write: drive the line high; read: synchronized pin level |
| direction | 0x10 | read/write | line is an output |
| sense | 0x90 | read/write | edge sensing |
| polarity | 0x94 | read/write | high level or rising edge |
| acknowledge | 0x98 | write 1 to clear, reads 0 | clear that line's latched edge |
| enable | 0x9c | read/write | line may interrupt |
| status | 0xa0 | read only | enabled, pending interrupt |
| filter | 0xa8 | read/write | debounce that input |

Read data appears on `bus_rdata` one clock after `bus_addr` is presented.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every writable register is 0: all lines are inputs, `pin_oe`=0, `pin_out`=0, and all interrupt outputs are 0.
- R2: A write to data (0x00) sets `pin_out`, and a write to direction (0x10) sets `pin_oe`, both on the next clock. A direction bit of 1 makes that line an output.
- R3: A read of data (0x00) returns the synchronized level of `pin_in`, valid within 3 clocks of a pin change.
- R4: With sense bit 0 (level), the line is pending while its filtered input equals its polarity bit. Polarity 1 means active high and 0 means active low. Pending clears when the level goes away, with no acknowledge.
- R5: With sense bit 1 (edge), a rising transition (polarity 1) or a falling transition (polarity 0) sets a latch. The latch stays set after the input returns.
- R6: Writing acknowledge (0x98) clears the latched edge of each bit written as 1. Bits written as 0 keep their latch.
- R7: Only lines whose enable bit (0x9c) is 1 can appear in status or on the interrupt outputs. Enable 0 silences every line.
- R8: With its filter bit (0xa8) set, an input pulse shorter than 3 clock cycles produces no interrupt. A level held for 4 consecutive sample ticks (default: 16 to 20 clocks) is accepted.
- R9: A write to sense (0x90) or polarity (0x94) that changes a line's bit clears that line's latched edge. Lines whose bits are unchanged keep their latch.
- R10: `irq_line[i]` equals status bit i one clock later, and `irq_any` is the OR of those bits.
- R11: Configuration registers read back the value written. Status (0xa0) returns the enabled pending bits, and acknowledge reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| bus_wr | input | 1 | write strobe for the addressed register |
| bus_addr | input | 8 | register byte address |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | registered read data for the previous cycle's address |
| pin_in | input | 8 | raw asynchronous pin levels |
| pin_out | output | 8 | output drive values |
| pin_oe | output | 8 | output enables, 1 = drive |
| irq_line | output | 8 | per-line interrupt requests |
| irq_any | output | 1 | OR of all line requests |

## Verification
On every cycle, the checker confirms the following:
- After reset, the drivers are off.
- Writes to data and direction reach the pins one clock later.
- No line interrupts unless its enable bit was set.
- The combined output always matches the per-line outputs.

Several behaviours depend on the history of a pin and of the bus, and only the bench scenarios show them:
- edge latching and its selective acknowledge
- level tracking in both polarities
- the latch clear when sense or polarity changes
- glitch rejection and acceptance by the filter

The bench compares these against models computed from the pin patterns it applies.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam logic [7:0] A_DATA   = 8'h00;
  localparam logic [7:0] A_DIR    = 8'h10;
  localparam logic [7:0] A_SENSE  = 8'h90;
  localparam logic [7:0] A_POL    = 8'h94;
  localparam logic [7:0] A_ACK    = 8'h98;
  localparam logic [7:0] A_EN     = 8'h9c;
  localparam logic [7:0] A_STATUS = 8'ha0;
  localparam logic [7:0] A_FILT   = 8'ha8;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int WIDTH  = 8,
  parameter int DIV    = 4,
  parameter int STABLE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int CW = $clog2(STABLE) + 1;
  localparam logic [PW-1:0] PMAX = PW'(DIV - 1);
  localparam logic [CW-1:0] CMAX = CW'(STABLE - 1);

  logic [PW-1:0] pre_q;
  logic          tick;

  always_ff @(posedge clk) begin
    if (rst || pre_q == PMAX) pre_q <= '0;
    else                      pre_q <= pre_q + 1'b1;
  end
  assign tick = (pre_q == PMAX);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q <= '0;
        q[i]  <= 1'b0;
      end else if (tick) begin
        if (d[i] == q[i]) begin
          cnt_q <= '0;
        end else if (cnt_q == CMAX) begin
          cnt_q <= '0;
          q[i]  <= d[i];
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl,
  input  logic [WIDTH-1:0] edge_mode,
  input  logic [WIDTH-1:0] high_rise,
  input  logic [WIDTH-1:0] enable,
  input  logic [WIDTH-1:0] ack_clr,
  input  logic [WIDTH-1:0] cfg_clr,
  output logic [WIDTH-1:0] status
);
  logic [WIDTH-1:0] prev_q, latch_q;
  logic [WIDTH-1:0] rise, fall, edge_hit, level_hit;

  assign rise      = lvl & ~prev_q;
  assign fall      = ~lvl & prev_q;
  assign edge_hit  = edge_mode & ((high_rise & rise) | (~high_rise & fall));
  assign level_hit = ~edge_mode & ~(lvl ^ high_rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= lvl;
      latch_q <= ((latch_q & ~ack_clr) | edge_hit) & ~cfg_clr;
    end
  end

  assign status = enable & ((edge_mode & latch_q) | level_hit);
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int DB_DIV    = 4,
  parameter int DB_STABLE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic [7:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] irq_line,
  output logic             irq_any
);
  logic [WIDTH-1:0] dir_q, sense_q, pol_q, en_q, filt_q;
  logic [WIDTH-1:0] sync_lvl, deb_lvl, det_lvl, status;
  logic [WIDTH-1:0] ack_clr, cfg_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      dir_q   <= '0;
      sense_q <= '0;
      pol_q   <= '0;
      en_q    <= '0;
      filt_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_DATA:  pin_out <= bus_wdata;
        A_DIR:   dir_q   <= bus_wdata;
        A_SENSE: sense_q <= bus_wdata;
        A_POL:   pol_q   <= bus_wdata;
        A_EN:    en_q    <= bus_wdata;
        A_FILT:  filt_q  <= bus_wdata;
        default: ;
      endcase
    end
  end
  assign pin_oe = dir_q;

  assign ack_clr = (bus_wr && bus_addr == A_ACK) ? bus_wdata : '0;
  assign cfg_clr = ((bus_wr && bus_addr == A_SENSE) ? (bus_wdata ^ sense_q) : '0)
                 | ((bus_wr && bus_addr == A_POL)   ? (bus_wdata ^ pol_q)   : '0);

  gpio_sync #(.WIDTH(WIDTH)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(sync_lvl)
  );

  gpio_debounce #(.WIDTH(WIDTH), .DIV(DB_DIV), .STABLE(DB_STABLE)) u_deb (
    .clk(clk), .rst(rst), .d(sync_lvl), .q(deb_lvl)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_sel
    assign det_lvl[i] = filt_q[i] ? deb_lvl[i] : sync_lvl[i];
  end

  gpio_irq_detect #(.WIDTH(WIDTH)) u_det (
    .clk(clk), .rst(rst), .lvl(det_lvl), .edge_mode(sense_q),
    .high_rise(pol_q), .enable(en_q), .ack_clr(ack_clr),
    .cfg_clr(cfg_clr), .status(status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_line  <= '0;
      irq_any   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      irq_line <= status;
      irq_any  <= |status;
      case (bus_addr)
        A_DATA:   bus_rdata <= sync_lvl;
        A_DIR:    bus_rdata <= dir_q;
        A_SENSE:  bus_rdata <= sense_q;
        A_POL:    bus_rdata <= pol_q;
        A_EN:     bus_rdata <= en_q;
        A_STATUS: bus_rdata <= status;
        A_FILT:   bus_rdata <= filt_q;
        default:  bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wr,
  input logic [7:0]       bus_addr,
  input logic [WIDTH-1:0] bus_wdata,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_oe,
  input logic [WIDTH-1:0] irq_line,
  input logic             irq_any,
  input logic [WIDTH-1:0] en_q
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && pin_out == '0 && irq_line == '0 && !irq_any));

  // R2
  data_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 8'h00) |=> (pin_out == $past(bus_wdata)));

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 8'h10) |=> (pin_oe == $past(bus_wdata)));

  // R7
  enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> (irq_line == '0));

  // R7
  enable_subset_chk: assert property (@(posedge clk) disable iff (rst)
    ((irq_line & ~$past(en_q)) == '0));

  // R10
  irq_or_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_any == (irq_line != '0)));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .irq_line(irq_line), .irq_any(irq_any), .en_q(en_q)
);

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] pin_out, pin_oe, irq_line;
  logic       irq_any;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_port u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_line(irq_line), .irq_any(irq_any)
  );

  function automatic logic [7:0] exp_level(input logic [7:0] en, pol, pins);
    return en & ~(pins ^ pol);
  endfunction

  function automatic logic [7:0] exp_edge(input logic [7:0] en, pol, p0, p1);
    return en & ((pol & ~p0 & p1) | (~pol & p0 & ~p1));
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] v, p0, p1, pol, en;
    void'($urandom(32'h5eed_1234));
    idle(3);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    check("R1 pin_oe", pin_oe, 8'h00);
    check("R1 pin_out", pin_out, 8'h00);
    check("R1 irq_line", irq_line, 8'h00);
    check("R1 irq_any", {7'd0, irq_any}, 8'h00);
    rd(8'h9c, v); check("R1 enable reg", v, 8'h00);

    // R2 output drive
    wr(8'h00, 8'hA5); check("R2 pin_out", pin_out, 8'hA5);
    wr(8'h10, 8'h3C); check("R2 pin_oe", pin_oe, 8'h3C);
    wr(8'h10, 8'h00);

    // R11 readback
    wr(8'ha8, 8'h00);
    wr(8'h94, 8'h5A); rd(8'h94, v); check("R11 polarity readback", v, 8'h5A);
    rd(8'h98, v); check("R11 ack reads zero", v, 8'h00);
    wr(8'h94, 8'h00);

    // R3 data read
    pin_in = 8'h96; idle(4);
    rd(8'h00, v); check("R3 data read", v, 8'h96);

    // R4 level mode, random patterns
    wr(8'h90, 8'h00);
    for (int k = 0; k < 20; k++) begin
      pol = 8'($urandom); en = 8'($urandom); p0 = 8'($urandom);
      wr(8'h94, pol); wr(8'h9c, en);
      pin_in = p0; idle(6);
      check("R4 level irq_line", irq_line, exp_level(en, pol, p0));
      check("R10 irq_any", {7'd0, irq_any}, {7'd0, exp_level(en, pol, p0) != 0});
      rd(8'ha0, v); check("R11 status read", v, exp_level(en, pol, p0));
    end

    // R7 enable zero silences level-active lines
    wr(8'h94, 8'hFF); pin_in = 8'hFF; wr(8'h9c, 8'h00); idle(6);
    check("R7 enable zero", irq_line, 8'h00);

    // R5 edge mode, random transitions
    wr(8'h90, 8'hFF);
    for (int k = 0; k < 20; k++) begin
      pol = 8'($urandom); en = 8'($urandom);
      p0 = 8'($urandom); p1 = 8'($urandom);
      pin_in = p0; idle(6);
      wr(8'h94, pol); wr(8'h9c, en); wr(8'h98, 8'hFF); idle(2);
      pin_in = p1; idle(6);
      check("R5 edge latch", irq_line, exp_edge(en, pol, p0, p1));
      pin_in = p0; idle(6);
      check("R5 latch holds", irq_line, exp_edge(en, pol, p0, p1) | exp_edge(en, pol, p1, p0));
    end

    // R6 selective acknowledge
    pin_in = 8'h00; idle(6);
    wr(8'h94, 8'hFF); wr(8'h9c, 8'hFF); wr(8'h98, 8'hFF); idle(2);
    pin_in = 8'h12; idle(6);
    check("R6 both latched", irq_line, 8'h12);
    wr(8'h98, 8'h02); idle(2);
    check("R6 ack bit1 only", irq_line, 8'h10);

    // R9 reconfiguration clears changed bits only
    wr(8'h98, 8'hFF); pin_in = 8'h00; idle(6);
    pin_in = 8'h0C; idle(6);
    check("R9 setup", irq_line, 8'h0C);
    wr(8'h94, 8'hFB); idle(2);
    check("R9 polarity change clears", irq_line, 8'h08);
    wr(8'h90, 8'hF7); wr(8'h90, 8'hFF); idle(2);
    check("R9 sense change clears", irq_line, 8'h00);

    // R8 debounce
    wr(8'h9c, 8'h00); pin_in = 8'h00; wr(8'ha8, 8'h01); idle(40);
    wr(8'h94, 8'h01); wr(8'h98, 8'hFF); wr(8'h9c, 8'h01);
    pin_in = 8'h01; idle(2); pin_in = 8'h00; idle(50);
    check("R8 glitch rejected", irq_line, 8'h00);
    pin_in = 8'h01; idle(50);
    check("R8 stable accepted", irq_line, 8'h01);

    summary();
  end
endmodule